// File: doc/BRIEF.md
# Quarter-Wave Compressed Sine Synthesizer

This block is a direct digital synthesis core that turns a frequency word and a phase offset into a stream of sine amplitude samples, one per clock. A 24-bit phase register gains the frequency word on each enabled clock edge. The phase offset is then added on top, and the thirteen most significant bits of the sum select a point on the sine period.

Only one quarter of the period is stored, in a 2048-entry table that is computed when the design is built. The two upper address bits locate the point within the period. One bit mirrors the table index, so the second quarter is read backwards. The other bit reflects the amplitude about mid-scale, which gives the negative half. The result is a full-period waveform in 8-bit offset binary, and it feeds a DAC or a later mixing stage.

The enable input is active low. While it is high, the phase register and the output sample hold their values. The sample is registered, so it shows the phase that was current before the clock edge that captured it.

Top module: `qwave_dds`

## Requirements
- R1: Synchronous active-high reset clears the phase register to 0 and sets the sample to mid-scale 128. The first enabled output after reset therefore reads the address equal to the phase offset word.
- R2: On every rising edge with enable low (enN = 0), the phase register increases by the 9-bit frequency word, modulo 2^24.
- R3: The lookup address is bits 23..11 of (phase register + phase word × 2^11) mod 2^24. Equivalently, it is (phase bits 23..11 + phase word) mod 8192.
- R4: Table entry k (0..2047) equals 128 + round(127·sin(π/2·(k+0.5)/2048)), within ±1. Every entry lies in 128..255.
- R5: When address bit 11 is 1, the table is read at index 2047 − (address bits 10..0). Otherwise it is read at address bits 10..0.
- R6: When address bit 12 is 1, the sample is 255 minus the table value, which gives a value in 0..127. Otherwise the sample is the table value itself.
- R7: The sample presented after an enabled edge is computed from the phase register and phase word as they were before that edge, which is one cycle of latency.
- R8: While enN is 1, the phase register and the sample keep their values, whatever the frequency and phase words do.
- R9: The phase register wraps from the top of its range to the bottom without a glitch, so the waveform continues across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enN | input | 1 | Run enable, active low |
| freqWord | input | 9 | Phase increment per enabled cycle |
| phaseWord | input | 11 | Phase offset, LSB weighted as one address step |
| sample | output | 8 | Offset-binary amplitude, mid-scale 128 |

## Verification
With a frequency word of zero, the phase offset alone walks single table entries: the first, the middle and the last entry, plus an arbitrary address. This separates table content and address alignment from accumulation. A small frequency word over a few cycles shows the increment step by step. The largest frequency word is then run for more than a full period, so all four quadrants and the register wrap are covered, and a wrong mirror or a wrong inversion gives errors far beyond the ±1 table tolerance. Disabled stretches with changing words are placed between the runs. They show that both the phase and the sample freeze, and that the wave resumes from the held phase.

// File: rtl/qwave_pkg.sv
package qwave_pkg;

  parameter int ACC_W  = 24;   // phase register width
  parameter int FCW_W  = 9;    // frequency word width
  parameter int PCW_W  = 11;   // phase word width
  parameter int ADDR_W = 13;   // full-period address width
  parameter int AMP_W  = 8;    // sample width

  localparam int IDX_W   = ADDR_W - 2;          // quarter-table index width
  localparam int TBL_N   = 1 << IDX_W;          // quarter-table depth
  localparam int SHIFT_W = ACC_W - ADDR_W;      // phase bits below the address
  localparam int MID     = 1 << (AMP_W - 1);    // offset-binary zero
  localparam int PEAK    = MID - 1;             // largest swing from mid-scale

  // control to datapath strobes
  typedef struct packed {
    logic advance;   // step the phase register
    logic capture;   // load a new output sample
  } dds_strobe_t;

  localparam int FRAC = 30;
  localparam longint PI_Q = 64'sd3373259426;    // pi in Q30

  // quarter sine, evaluated at the bin centre, by an odd Taylor series in Q30
  function automatic logic [AMP_W-1:0] quarterSine(input int k);
    longint x;
    longint x2;
    longint term;
    longint sum;
    longint scaled;
    x    = ((2 * longint'(k) + 1) * PI_Q) / (4 * longint'(TBL_N));
    x2   = (x * x) >>> FRAC;
    term = x;
    sum  = x;
    for (int n = 1; n <= 6; n++) begin
      term = -((term * x2) >>> FRAC) / longint'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    scaled = (longint'(PEAK) * sum + (longint'(1) <<< (FRAC - 1))) >>> FRAC;
    return AMP_W'(longint'(MID) + scaled);
  endfunction

endpackage

// File: rtl/qwave_ctrl.sv
module qwave_ctrl
  import qwave_pkg::*;
(
  input  logic        rst,
  input  logic        enN,
  output dds_strobe_t strobe
);

  // active-low run enable drives both the phase step and the sample load
  always_comb begin
    strobe.advance = !rst && !enN;
    strobe.capture = !rst && !enN;
  end

endmodule

// File: rtl/qwave_rom.sv
module qwave_rom
  import qwave_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output logic [AMP_W-1:0] amp
);

  logic [AMP_W-1:0] quarterTbl [TBL_N];

  for (genvar g = 0; g < TBL_N; g++) begin : g_fill
    assign quarterTbl[g] = quarterSine(g);
  end

  assign amp = quarterTbl[idx];

endmodule

// File: rtl/qwave_datapath.sv
module qwave_datapath
  import qwave_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  dds_strobe_t       strobe,
  input  logic [FCW_W-1:0]  freqWord,
  input  logic [PCW_W-1:0]  phaseWord,
  output logic [ACC_W-1:0]  accValue,
  output logic [ADDR_W-1:0] lutAddr,
  output logic [AMP_W-1:0]  sample
);

  logic [ACC_W-1:0] phaseAcc;
  logic [ACC_W-1:0] offsetPhase;
  logic [IDX_W-1:0] tblIdx;
  logic [AMP_W-1:0] tblAmp;
  logic [AMP_W-1:0] foldAmp;
  logic             mirrorBit;
  logic             invertBit;

  // phase register
  always_ff @(posedge clk) begin
    if (rst)                 phaseAcc <= '0;
    else if (strobe.advance) phaseAcc <= phaseAcc + ACC_W'(freqWord);
  end

  // phase offset, LSB aligned with address bit 0
  assign offsetPhase = phaseAcc + (ACC_W'(phaseWord) << SHIFT_W);
  assign lutAddr     = offsetPhase[ACC_W-1 -: ADDR_W];

  assign mirrorBit = lutAddr[IDX_W];
  assign invertBit = lutAddr[IDX_W+1];

  // address converter: read the quarter backwards on odd quadrants
  assign tblIdx = mirrorBit ? ~lutAddr[IDX_W-1:0] : lutAddr[IDX_W-1:0];

  qwave_rom romInst (
    .idx (tblIdx),
    .amp (tblAmp)
  );

  // amplitude converter: reflect about mid-scale on the negative half
  assign foldAmp = invertBit ? ~tblAmp : tblAmp;

  always_ff @(posedge clk) begin
    if (rst)                 sample <= AMP_W'(MID);
    else if (strobe.capture) sample <= foldAmp;
  end

  assign accValue = phaseAcc;

endmodule

// File: rtl/qwave_dds.sv
module qwave_dds
  import qwave_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enN,
  input  logic [8:0]  freqWord,
  input  logic [10:0] phaseWord,
  output logic [7:0]  sample
);

  dds_strobe_t       strobe;
  logic [ACC_W-1:0]  accValue;
  logic [ADDR_W-1:0] lutAddr;

  qwave_ctrl ctrlInst (
    .rst    (rst),
    .enN    (enN),
    .strobe (strobe)
  );

  qwave_datapath dpInst (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .freqWord  (freqWord),
    .phaseWord (phaseWord),
    .accValue  (accValue),
    .lutAddr   (lutAddr),
    .sample    (sample)
  );

endmodule

// File: rtl/qwave_dds_chk.sv
module qwave_dds_chk
  import qwave_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              enN,
  input logic [FCW_W-1:0]  freqWord,
  input logic [ACC_W-1:0]  accValue,
  input logic [ADDR_W-1:0] lutAddr,
  input logic [AMP_W-1:0]  sample
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (accValue == '0) && (sample == AMP_W'(MID)));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    !enN |=> accValue == ACC_W'($past(accValue) + ACC_W'($past(freqWord))));

  // R6
  half_select_chk: assert property (@(posedge clk) disable iff (rst)
    !enN |=> sample[AMP_W-1] == !$past(lutAddr[ADDR_W-1]));

  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    enN |=> $stable(accValue));

  // R8
  sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
    enN |=> $stable(sample));

endmodule

bind qwave_dds qwave_dds_chk chkInst (
  .clk      (clk),
  .rst      (rst),
  .enN      (enN),
  .freqWord (freqWord),
  .accValue (accValue),
  .lutAddr  (lutAddr),
  .sample   (sample)
);

// File: tb/qwave_dds_test.sv
module qwave_dds_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enN = 1'b1;
  logic [8:0]  freqWord = '0;
  logic [10:0] phaseWord = '0;
  logic [7:0]  sample;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int    expQ[$];
  bit    holdQ[$];
  string reqQ[$];

  int accModel = 0;
  int lastExp = 128;
  int prevActual = 128;

  always #4 clk = ~clk;

  qwave_dds uut (
    .clk       (clk),
    .rst       (rst),
    .enN       (enN),
    .freqWord  (freqWord),
    .phaseWord (phaseWord),
    .sample    (sample)
  );

  // reference amplitude from the requirements (R3..R6)
  function automatic int refSample(input int acc, input int pw);
    int addr;
    int low;
    int idx;
    int v;
    addr = ((acc >> 11) + pw) & 8191;
    low  = addr & 2047;
    idx  = ((addr >> 11) & 1) != 0 ? 2047 - low : low;
    v    = 128 + $rtoi(127.0 * $sin(3.14159265358979 * (real'(idx) + 0.5) / 4096.0) + 0.5);
    return ((addr >> 12) & 1) != 0 ? 255 - v : v;
  endfunction

  task automatic check(input string req, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(input bit en, input int f, input int p, input string req);
    int e;
    @(negedge clk);
    enN = en;
    freqWord = 9'(f);
    phaseWord = 11'(p);
    if (!en) begin
      e = refSample(accModel, p);
      accModel = (accModel + f) & 24'hFFFFFF;
      lastExp = e;
    end else begin
      e = lastExp;
    end
    expQ.push_back(e);
    holdQ.push_back(en);
    reqQ.push_back(req);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        int e;
        bit h;
        string r;
        e = expQ.pop_front();
        h = holdQ.pop_front();
        r = reqQ.pop_front();
        if (h) check({r, " hold"}, int'(sample), prevActual, 0);
        else   check(r, int'(sample), e, 1);
      end
      prevActual = int'(sample);
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset sample", int'(sample), 128, 0);

    // R8 idle after reset keeps mid-scale
    for (int i = 0; i < 3; i++) step(1'b1, 37 + i, 500 + i, "R8");

    // R1 R4 first enabled output reads address = phase word
    step(1'b0, 0, 0, "R1 R4 entry0");
    step(1'b0, 0, 1023, "R3 R4 entry1023");
    step(1'b0, 0, 2047, "R3 R4 entry2047");
    step(1'b0, 0, 180, "R3 R4 entry180");

    // R2 R7 small increments
    for (int i = 0; i < 6; i++) step(1'b0, 1, 2040, "R2 R7 small step");
    for (int i = 0; i < 8; i++) step(1'b0, 500, 2047, "R2 R3 carry");

    // R8 freeze with moving words
    for (int i = 0; i < 12; i++) step(1'b1, 17 * i, 97 * i, "R8");

    // R5 R6 R9 more than a full period at the largest step
    for (int i = 0; i < 33500; i++) step(1'b0, 511, 0, "R5 R6 R9 sweep");

    // R8 then resume from held phase
    for (int i = 0; i < 10; i++) step(1'b1, 3, 3, "R8");
    for (int i = 0; i < 2000; i++) step(1'b0, 300, 1500, "R7 resume");

    // R1 reset in the middle of a run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run reset sample", int'(sample), 128, 0);
    accModel = 0;
    lastExp = 128;
    step(1'b0, 0, 700, "R1 restart address");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule